// File: doc/BRIEF.md
# Top-Relative Register Stack for a Multiply Unit

The block holds eight operand registers for a floating-point multiply unit. Every register is named by its distance from a rotating 3-bit top pointer, and each one carries a tag that marks it valid or empty. An operation names a form and an index `i`. The block then presents ST(0) and ST(i) as operands. ST(k) is the physical entry (top + k) mod 8.

The product is computed outside the block. It comes back on `op_result` in the same cycle that `op_valid` is high. On that clock edge the block writes the product to ST(0) or to ST(i), as the form selects. Some forms also pop the stack: the entry at the top is tagged empty and the pointer advances by one. The write always happens before the pop.

If any source register the form reads is empty, the operation is refused. Nothing is written, nothing is popped, an underflow flag is raised and the condition bit is cleared. A test-only load port can fill any physical entry and tag it valid.

Top module: `fpstk_mul_regfile`

## Requirements
- R1: After reset the top pointer is 0, every tag is empty (`tag_valid` bit k reflects physical entry k, 1 = valid), and `uf_flag` and `c1_flag` are 0.
- R2: With `op_valid` low, setting `op_form`=1 and `op_idx`=k shows ST(0) on `opnd_a` and ST(k) on `opnd_b`, where ST(k) is physical entry (top + k) mod 8.
- R3: Form code 4 ignores `op_idx`. It reads ST(0) and ST(1), writes the product to ST(1) and then pops, so the product becomes the new ST(0).
- R4: A pop tags the entry at the top empty and advances the pointer by one, wrapping from 7 to 0.
- R5: Form code 1 reads ST(0) and ST(i) and writes the product to ST(0). It does not pop, and ST(i) is left unchanged when i is not 0.
- R6: Form code 2 reads ST(0) and ST(i) and writes the product to ST(i). It does not pop, and ST(0) is left unchanged when i is not 0.
- R7: Form code 3 writes the product to ST(i) and then pops. With i=1 the product becomes the new ST(0). With i=0 the product lands in the entry that the pop then empties.
- R8: Form code 0 (memory source) reads only ST(0) and writes the product to ST(0). An empty ST(i) causes no underflow in this form.
- R9: If a source register the form reads is empty, the operation has no effect on data, tags or pointer. `uf_flag` is 1 in the cycle after that edge and 0 after any cycle without such a fault, and `c1_flag` becomes 0.
- R10: An accepted operation loads `c1_flag` from `op_round_up`. `c1_flag` holds its value while `op_valid` is low.
- R11: A test load with `tl_en` high writes `tl_data` to physical entry `tl_phys` and tags that entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Commit the operation on this edge |
| op_form | input | 3 | Operation form code (0 to 4) |
| op_idx | input | PTR_W | Stack index i |
| op_result | input | DATA_W | Product returned by the multiply unit |
| op_round_up | input | 1 | The product was rounded up |
| tl_en | input | 1 | Test load enable |
| tl_phys | input | PTR_W | Physical entry for the test load |
| tl_data | input | DATA_W | Test load value |
| opnd_a | output | DATA_W | ST(0) value |
| opnd_b | output | DATA_W | ST(i) value (0 for form 0) |
| uf_flag | output | 1 | Underflow in the previous operation |
| c1_flag | output | 1 | Condition bit |
| top_ptr | output | PTR_W | Current top pointer |
| tag_valid | output | 2**PTR_W | Valid tag per physical entry |

## Verification
The operand outputs are combinational from the form, the index and the stored state, so they are valid in the same cycle the inputs are set. Writes, pops, `top_ptr`, `tag_valid`, `uf_flag` and `c1_flag` change on the single clock edge where `op_valid` is high and are visible one cycle later. The bench drives every input on the falling edge. It samples the flags at the falling edge right after the committing rising edge, before any idle edge can clear `uf_flag`. It only then walks the stack through the operand outputs with `op_valid` low.

// File: rtl/fpstk_pkg.sv
`timescale 1ns/1ps
package fpstk_pkg;

  localparam logic [2:0] FORM_MEM      = 3'd0;
  localparam logic [2:0] FORM_TO_ST0   = 3'd1;
  localparam logic [2:0] FORM_TO_STI   = 3'd2;
  localparam logic [2:0] FORM_STI_POP  = 3'd3;
  localparam logic [2:0] FORM_NOARG    = 3'd4;

  typedef struct packed {
    logic need_sti;   // form reads ST(i)
    logic dst_sti;    // result goes to ST(i) rather than ST(0)
    logic pop;        // pop after the write
    logic fixed_one;  // index forced to 1
  } form_ctl_t;

  function automatic form_ctl_t decode_form(input logic [2:0] form);
    form_ctl_t c;
    c = '0;
    case (form)
      FORM_TO_ST0:  c.need_sti = 1'b1;
      FORM_TO_STI:  begin c.need_sti = 1'b1; c.dst_sti = 1'b1; end
      FORM_STI_POP: begin c.need_sti = 1'b1; c.dst_sti = 1'b1; c.pop = 1'b1; end
      FORM_NOARG:   begin c.need_sti = 1'b1; c.dst_sti = 1'b1; c.pop = 1'b1;
                          c.fixed_one = 1'b1; end
      default:      c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fpstk_decode.sv
`timescale 1ns/1ps
module fpstk_decode
  import fpstk_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic [2:0]       form,
  input  logic [PTR_W-1:0] idx_in,
  output form_ctl_t        ctl,
  output logic [PTR_W-1:0] idx_eff
);

  always_comb begin
    ctl     = decode_form(form);
    idx_eff = ctl.fixed_one ? PTR_W'(1) : idx_in;
  end

  always_comb begin
    if (form == FORM_NOARG) begin
      p_noarg_shape_r3: assert (ctl.pop && ctl.dst_sti && idx_eff == PTR_W'(1));
    end
  end

endmodule

// File: rtl/fpstk_regs.sv
`timescale 1ns/1ps
module fpstk_regs #(
  parameter int DATA_W = 80,
  parameter int PTR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PTR_W-1:0]          top,
  input  logic [PTR_W-1:0]          rd_a_phys,
  input  logic [PTR_W-1:0]          rd_b_phys,
  output logic [DATA_W-1:0]         rd_a,
  output logic [DATA_W-1:0]         rd_b,
  output logic                      tag_a,
  output logic                      tag_b,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_phys,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      pop_en,
  input  logic                      tl_en,
  input  logic [PTR_W-1:0]          tl_phys,
  input  logic [DATA_W-1:0]         tl_data,
  output logic [(1<<PTR_W)-1:0]     tags
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic [DEPTH-1:0]             tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem   <= '0;
      tag_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (tl_en && tl_phys == PTR_W'(k)) begin
          mem[k]   <= tl_data;
          tag_q[k] <= 1'b1;
        end else begin
          if (wr_en && wr_phys == PTR_W'(k)) mem[k] <= wr_data;
          if (pop_en && top == PTR_W'(k))    tag_q[k] <= 1'b0;
        end
      end
    end
  end

  assign rd_a  = mem[rd_a_phys];
  assign rd_b  = mem[rd_b_phys];
  assign tag_a = tag_q[rd_a_phys];
  assign tag_b = tag_q[rd_b_phys];
  assign tags  = tag_q;

  p_pop_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !(tl_en && tl_phys == top)) |=> !tag_q[$past(top)]);

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tl_en) |=> mem[$past(wr_phys)] == $past(wr_data));

endmodule

// File: rtl/fpstk_mul_regfile.sv
`timescale 1ns/1ps
module fpstk_mul_regfile
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int PTR_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [2:0]            op_form,
  input  logic [PTR_W-1:0]      op_idx,
  input  logic [DATA_W-1:0]     op_result,
  input  logic                  op_round_up,
  input  logic                  tl_en,
  input  logic [PTR_W-1:0]      tl_phys,
  input  logic [DATA_W-1:0]     tl_data,
  output logic [DATA_W-1:0]     opnd_a,
  output logic [DATA_W-1:0]     opnd_b,
  output logic                  uf_flag,
  output logic                  c1_flag,
  output logic [PTR_W-1:0]      top_ptr,
  output logic [(1<<PTR_W)-1:0] tag_valid
);

  localparam int DEPTH = 1 << PTR_W;

  form_ctl_t          ctl;
  logic [PTR_W-1:0]   idx_eff;
  logic [PTR_W-1:0]   top_q;
  logic [PTR_W-1:0]   phys_a, phys_b, wr_phys;
  logic [DATA_W-1:0]  rd_a, rd_b;
  logic               tag_a, tag_b;
  logic [DEPTH-1:0]   tags;
  logic               uf_ev, commit_ev, fault_ev, pop_en;
  logic               uf_q, c1_q;

  fpstk_decode #(.PTR_W(PTR_W)) u_dec (
    .form    (op_form),
    .idx_in  (op_idx),
    .ctl     (ctl),
    .idx_eff (idx_eff)
  );

  assign phys_a    = top_q;
  assign phys_b    = top_q + idx_eff;   // wraps modulo DEPTH
  assign uf_ev     = !tag_a || (ctl.need_sti && !tag_b);
  assign commit_ev = op_valid && !uf_ev;
  assign fault_ev  = op_valid && uf_ev;
  assign pop_en    = commit_ev && ctl.pop;
  assign wr_phys   = ctl.dst_sti ? phys_b : phys_a;

  fpstk_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .top       (top_q),
    .rd_a_phys (phys_a),
    .rd_b_phys (phys_b),
    .rd_a      (rd_a),
    .rd_b      (rd_b),
    .tag_a     (tag_a),
    .tag_b     (tag_b),
    .wr_en     (commit_ev),
    .wr_phys   (wr_phys),
    .wr_data   (op_result),
    .pop_en    (pop_en),
    .tl_en     (tl_en),
    .tl_phys   (tl_phys),
    .tl_data   (tl_data),
    .tags      (tags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      uf_q  <= 1'b0;
      c1_q  <= 1'b0;
    end else begin
      if (pop_en) top_q <= top_q + PTR_W'(1);
      uf_q <= fault_ev;
      if (op_valid) c1_q <= commit_ev ? op_round_up : 1'b0;
    end
  end

  assign opnd_a    = rd_a;
  assign opnd_b    = ctl.need_sti ? rd_b : '0;
  assign uf_flag   = uf_q;
  assign c1_flag   = c1_q;
  assign top_ptr   = top_q;
  assign tag_valid = tags;

  p_pop_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> top_q == PTR_W'($past(top_q) + PTR_W'(1)));

  p_uf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && !tl_en) |=> (top_q == $past(top_q)) && (tags == $past(tags)));

  p_uf_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> uf_q && !c1_q);

  p_c1_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(c1_q));

endmodule

// File: tb/sim_fpstk_mul_regfile.sv
`timescale 1ns/1ps
module sim_fpstk_mul_regfile;

  localparam int DW = 80;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_form = 3'd1;
  logic [PW-1:0] op_idx = '0;
  logic [DW-1:0] op_result = '0;
  logic          op_round_up = 1'b0;
  logic          tl_en = 1'b0;
  logic [PW-1:0] tl_phys = '0;
  logic [DW-1:0] tl_data = '0;
  logic [DW-1:0] opnd_a, opnd_b;
  logic          uf_flag, c1_flag;
  logic [PW-1:0] top_ptr;
  logic [7:0]    tag_valid;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] m_data [8];
  logic [7:0]    m_tag;
  logic [2:0]    m_top;

  always #2.5 clk = ~clk;

  fpstk_mul_regfile #(.DATA_W(DW), .PTR_W(PW)) u0 (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int p, input logic [DW-1:0] d);
    @(negedge clk);
    tl_en = 1'b1; tl_phys = PW'(p); tl_data = d;
    @(negedge clk);
    tl_en = 1'b0;
    m_data[p] = d; m_tag[p] = 1'b1;
  endtask

  // Applies one operation to DUT and model; flags checked right after the edge.
  task automatic do_op(input string req, input logic [2:0] f, input int i,
                       input logic [DW-1:0] res, input logic rnd);
    int ie, pa, pb, pd;
    logic fault, rd_i;
    ie = (f == 3'd4) ? 1 : i;
    pa = m_top;
    pb = (m_top + ie) % 8;
    rd_i = (f != 3'd0);
    fault = !m_tag[pa] || (rd_i && !m_tag[pb]);
    @(negedge clk);
    op_form = f; op_idx = PW'(i); op_result = res; op_round_up = rnd; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (!fault) begin
      pd = (f == 3'd0 || f == 3'd1) ? pa : pb;
      m_data[pd] = res;
      if (f == 3'd3 || f == 3'd4) begin
        m_tag[m_top] = 1'b0;
        m_top = m_top + 3'd1;
      end
    end
    chk({req, " uf_flag"}, DW'(uf_flag), DW'(fault));
    chk({req, " c1_flag"}, DW'(c1_flag), DW'(fault ? 1'b0 : rnd));
  endtask

  task automatic check_state(input string req);
    chk({req, " top"}, DW'(top_ptr), DW'(m_top));
    chk({req, " tags"}, DW'(tag_valid), DW'(m_tag));
    op_form = 3'd1;
    for (int k = 0; k < 8; k++) begin
      op_idx = PW'(k);
      #0.5;
      if (m_tag[(m_top + k) % 8]) chk({req, " ST(k) via opnd_b"}, opnd_b, m_data[(m_top + k) % 8]);
    end
  endtask

  task automatic t_reset;
    chk("R1 top", DW'(top_ptr), '0);
    chk("R1 tags", DW'(tag_valid), '0);
    chk("R1 uf", DW'(uf_flag), '0);
    chk("R1 c1", DW'(c1_flag), '0);
  endtask

  task automatic t_load;
    for (int k = 0; k < 4; k++) load(k, DW'(32'h100 + k));
    chk("R11 tags after load", DW'(tag_valid), DW'(8'h0F));
    @(negedge clk); op_form = 3'd1; op_idx = 3'd2; #0.5;
    chk("R2 ST(2)", opnd_b, DW'(32'h102));
    chk("R2 ST(0)", opnd_a, DW'(32'h100));
    check_state("R11");
  endtask

  task automatic t_form1;
    do_op("R5 R10 form1", 3'd1, 2, DW'(32'hA1), 1'b1);
    check_state("R5");
  endtask

  task automatic t_form2;
    do_op("R6 R10 form2", 3'd2, 3, DW'(32'hB2), 1'b0);
    check_state("R6");
  endtask

  task automatic t_mem;
    do_op("R8 mem form", 3'd0, 5, DW'(32'hC3), 1'b1);
    check_state("R8");
  endtask

  task automatic t_uf;
    do_op("R9 empty ST(6)", 3'd1, 6, DW'(32'hDEAD), 1'b1);
    check_state("R9");
    @(negedge clk);
    chk("R9 uf clears", DW'(uf_flag), '0);
    chk("R10 c1 holds", DW'(c1_flag), '0);
  endtask

  task automatic t_form3;
    do_op("R7 form3 i=1", 3'd3, 1, DW'(32'hD4), 1'b0);
    @(negedge clk); op_form = 3'd1; op_idx = 3'd0; #0.5;
    chk("R7 new ST(0)", opnd_a, DW'(32'hD4));
    check_state("R7 R4 R2");
  endtask

  task automatic t_noarg;
    do_op("R3 noarg", 3'd4, 7, DW'(32'hE5), 1'b1);
    @(negedge clk); op_form = 3'd1; op_idx = 3'd0; #0.5;
    chk("R3 new ST(0)", opnd_a, DW'(32'hE5));
    chk("R3 top", DW'(top_ptr), DW'(3'd2));
    check_state("R3");
  endtask

  task automatic t_wrap;
    for (int k = 2; k < 8; k++) load(k, DW'(32'h200 + k));
    for (int k = 0; k < 6; k++) do_op("R7 R4 pop i=0", 3'd3, 0, DW'(32'hF0 + k), 1'b0);
    chk("R4 wrap to 0", DW'(top_ptr), '0);
    check_state("R4");
  endtask

  task automatic t_noarg_uf;
    load(0, DW'(32'h300));
    do_op("R9 R3 noarg ST(1) empty", 3'd4, 0, DW'(32'h77), 1'b1);
    check_state("R9 noarg");
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m_data[k] = '0;
    m_tag = '0; m_top = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_form1();
    t_form2();
    t_mem();
    t_uf();
    t_form3();
    t_noarg();
    t_wrap();
    t_noarg_uf();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule